// File: doc/BRIEF.md
# SD Card Command Issue Engine

This block issues a single command to an SD card over the serial command line and gathers the card's reply. Software sets it up through a small word-addressed register set: it loads the 32-bit argument, may change the response timeout, and then writes the command word with the start flag set. The engine serialises a 48-bit frame, protected by CRC7, onto the command line. It then either finishes at once, or receives a 48-bit or 136-bit response. After that it can optionally wait for the card to release its busy indication on data line 0.

The card clock comes from an internal divider. Outgoing bits change on its falling edge, and incoming bits are sampled on its rising edge. Completion is signalled by the start flag dropping back to zero. Errors set a fail flag in the command word, with the cause kept in a write-1-to-clear status register.

The controller is built around one state machine with these states:
- S_IDLE: waiting for a start.
- S_SEND: shifting out the frame.
- S_WAIT: counting down the timeout while watching for a start bit.
- S_RECV: shifting in the response.
- S_CHECK: checking CRC and storing the response.
- S_BUSY: waiting for data line 0 to go high.
- S_DONE: clearing the start flag.

Its transitions are:
- S_IDLE to S_SEND on a start write.
- S_SEND to S_WAIT after the end bit when a response is expected. Otherwise S_SEND goes to S_BUSY or S_DONE.
- S_WAIT to S_RECV on a start bit, or to S_DONE when the timeout expires.
- S_RECV to S_CHECK after the last bit.
- S_CHECK to S_BUSY when a busy wait is requested and the CRC is good. Otherwise S_CHECK goes to S_DONE.
- S_BUSY to S_DONE on release or on timeout.
- S_DONE to S_IDLE.

Top module: `sd_cmd_engine`

## Requirements
- R1: After reset the command word (word 0) and the status register (word 3) read 0, the timeout register (word 2) reads 0x00F00000, cmd_oe is 0 and cmd_out is 1.
- R2: Register words: 0 is the command word, 1 the argument, 2 the timeout, 3 the status, and 4 to 7 the responses. In the command word, bits 5:0 are the index, bit 6 the read flag, bit 7 the write flag, bit 9 selects a long response, bit 10 selects no response, bit 11 requests a busy wait, bit 14 is the fail flag and bit 15 is the start flag. Writing word 0 with bit 15 set while idle starts a command. Bit 15 then reads 1 until the command has finished.
- R3: The frame is 48 bits sent MSB first. It consists of a start bit 0, a transmission bit 1, the index, the argument, the CRC7 (x^7+x^3+1) of the preceding 40 bits, and an end bit 1. cmd_oe is high only while the frame is driven, and cmd_out changes only on falling card-clock edges.
- R4: A command with the no-response bit set finishes after its frame with the fail flag clear.
- R5: A short response is taken to begin at the first 0 seen on a rising edge, and 47 more bits follow it. Its bits 39:8 are stored in word 4.
- R6: When the CRC7 over bits 47:8 of a short response differs from bits 7:1, status bit 4 and the fail flag are set.
- R7: A long response is 136 bits. Its bits 127:0 are stored with bits 31:0 in word 4 through bits 127:96 in word 7.
- R8: While waiting for a response, a down-counter loaded from the timeout register steps once per card clock. If no start bit has appeared after (timeout+1) rising edges, status bit 6 and the fail flag are set.
- R9: With a busy wait requested, the engine finishes only once dat0_in is sampled high, and it then sets status bit 10. If dat0_in stays low for (timeout+1) card clocks, status bit 7 and the fail flag are set instead.
- R10: Status bits are cleared by writing 1 to them. Writing 0 leaves them unchanged.
- R11: While a command is active, writes to words 0, 1 and 2 are ignored. The frame in progress, the argument and the timeout keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| sd_clk | output | 1 | Card clock |
| cmd_out | output | 1 | Command line output value |
| cmd_oe | output | 1 | Command line output enable |
| cmd_in | input | 1 | Command line input from the card |
| dat0_in | input | 1 | Data line 0, sampled for busy |

## Verification
The assertions take several things for granted about the inputs. The command line input must idle high whenever the card is not driving it. The card must change cmd_in and dat0_in only around falling card-clock edges, so that every rising-edge sample is settled. Software is assumed not to issue a start while the engine is still active. The bench's card model meets these assumptions in three ways: it drives each response bit just after a falling edge of sd_clk, it releases the line to 1 after the end bit, and it only toggles dat0_in well clear of rising edges. The bench also polls for completion before it starts each new command.

// File: rtl/sd_cmd_pkg.sv
`timescale 1ns/1ps
package sd_cmd_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_SEND, S_WAIT, S_RECV, S_CHECK, S_BUSY, S_DONE
    } eng_state_t;

    localparam int FRAME_BITS = 48;
    localparam int LONG_BITS  = 136;
    localparam int CRC_SPAN   = 40;

    localparam logic [2:0] A_CMD  = 3'd0;
    localparam logic [2:0] A_ARG  = 3'd1;
    localparam logic [2:0] A_TOUT = 3'd2;
    localparam logic [2:0] A_STS  = 3'd3;

    localparam int CW_RD     = 6;
    localparam int CW_WR     = 7;
    localparam int CW_LONG   = 9;
    localparam int CW_NORESP = 10;
    localparam int CW_BUSY   = 11;
    localparam int CW_FAIL   = 14;
    localparam int CW_START  = 15;

    localparam int ST_CRC   = 4;
    localparam int ST_CTOUT = 6;
    localparam int ST_BTOUT = 7;
    localparam int ST_BDONE = 10;
endpackage

// File: rtl/sd_clkgen.sv
`timescale 1ns/1ps
module sd_clkgen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic sd_clk,
    output logic tick_rise,
    output logic tick_fall
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          clk_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            clk_q <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            clk_q <= ~clk_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign sd_clk    = clk_q;
    assign tick_rise = (cnt_q == LAST) && !clk_q;
    assign tick_fall = (cnt_q == LAST) && clk_q;
endmodule

// File: rtl/sd_crc7.sv
`timescale 1ns/1ps
module sd_crc7 #(
    parameter int W = 40
) (
    input  logic [W-1:0] bits,
    output logic [6:0]   crc
);
    always_comb begin
        logic [6:0] c;
        logic       fb;
        c = '0;
        for (int i = W - 1; i >= 0; i--) begin
            fb = bits[i] ^ c[6];
            c  = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        crc = c;
    end
endmodule

// File: rtl/sd_cmd_engine.sv
`timescale 1ns/1ps
module sd_cmd_engine
    import sd_cmd_pkg::*;
#(
    parameter int          HALF_DIV   = 2,
    parameter logic [31:0] TOUT_RESET = 32'h00F0_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        sd_clk,
    output logic        cmd_out,
    output logic        cmd_oe,
    input  logic        cmd_in,
    input  logic        dat0_in
);
    localparam int TXC_W = $clog2(FRAME_BITS + 1);
    localparam int RXC_W = $clog2(LONG_BITS);
    localparam logic [TXC_W-1:0] TX_LOAD    = TXC_W'(FRAME_BITS);
    localparam logic [RXC_W-1:0] RX_SHORT_N = RXC_W'(FRAME_BITS - 1);
    localparam logic [RXC_W-1:0] RX_LONG_N  = RXC_W'(LONG_BITS - 1);

    eng_state_t state_q, state_d;

    logic        tick_rise, tick_fall;
    logic [5:0]  cw_idx;
    logic        cw_rd, cw_wr, cw_long, cw_noresp, cw_busy, cw_fail, cw_start;
    logic [31:0] arg_q, tout_q, tout_cnt;
    logic        sts_bdone, sts_btout, sts_ctout, sts_crc;
    logic [31:0] resp_q [4];
    logic [FRAME_BITS-1:0] tx_sr;
    logic [TXC_W-1:0]      tx_left;
    logic [127:0]          rx_sr;
    logic [RXC_W-1:0]      rx_left;
    logic [6:0]  tx_crc, rx_crc;
    logic        start_wr, crc_bad;

    sd_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
        .clk(clk), .rst_n(rst_n), .sd_clk(sd_clk),
        .tick_rise(tick_rise), .tick_fall(tick_fall)
    );

    sd_crc7 #(.W(CRC_SPAN)) u_txcrc (
        .bits({2'b01, reg_wdata[5:0], arg_q}), .crc(tx_crc)
    );

    sd_crc7 #(.W(CRC_SPAN)) u_rxcrc (
        .bits(rx_sr[47:8]), .crc(rx_crc)
    );

    assign start_wr = reg_we && (reg_addr == A_CMD) && reg_wdata[CW_START]
                      && (state_q == S_IDLE);
    assign crc_bad  = !cw_long && (rx_crc != rx_sr[7:1]);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start_wr) state_d = S_SEND;
            S_SEND:  if (tick_fall && tx_left == '0)
                         state_d = !cw_noresp ? S_WAIT : (cw_busy ? S_BUSY : S_DONE);
            S_WAIT:  if (tick_rise) begin
                         if (!cmd_in)               state_d = S_RECV;
                         else if (tout_cnt == '0)   state_d = S_DONE;
                     end
            S_RECV:  if (tick_rise && rx_left == RXC_W'(1)) state_d = S_CHECK;
            S_CHECK: state_d = (cw_busy && !crc_bad) ? S_BUSY : S_DONE;
            S_BUSY:  if (tick_rise && (dat0_in || tout_cnt == '0)) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // registers and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {cw_idx, cw_rd, cw_wr, cw_long, cw_noresp, cw_busy, cw_fail, cw_start} <= '0;
            arg_q    <= '0;
            tout_q   <= TOUT_RESET;
            tout_cnt <= '0;
            {sts_bdone, sts_btout, sts_ctout, sts_crc} <= '0;
            for (int k = 0; k < 4; k++) resp_q[k] <= '0;
            tx_sr    <= '0;
            tx_left  <= '0;
            rx_sr    <= '0;
            rx_left  <= '0;
            cmd_out  <= 1'b1;
            cmd_oe   <= 1'b0;
        end else begin
            if (reg_we && reg_addr == A_STS) begin
                if (reg_wdata[ST_BDONE]) sts_bdone <= 1'b0;
                if (reg_wdata[ST_BTOUT]) sts_btout <= 1'b0;
                if (reg_wdata[ST_CTOUT]) sts_ctout <= 1'b0;
                if (reg_wdata[ST_CRC])   sts_crc   <= 1'b0;
            end
            if (reg_we && state_q == S_IDLE) begin
                if (reg_addr == A_ARG)  arg_q  <= reg_wdata;
                if (reg_addr == A_TOUT) tout_q <= reg_wdata;
                if (reg_addr == A_CMD) begin
                    cw_idx    <= reg_wdata[5:0];
                    cw_rd     <= reg_wdata[CW_RD];
                    cw_wr     <= reg_wdata[CW_WR];
                    cw_long   <= reg_wdata[CW_LONG];
                    cw_noresp <= reg_wdata[CW_NORESP];
                    cw_busy   <= reg_wdata[CW_BUSY];
                    cw_start  <= reg_wdata[CW_START];
                    if (reg_wdata[CW_START]) cw_fail <= 1'b0;
                    else                     cw_fail <= reg_wdata[CW_FAIL];
                end
            end
            if (start_wr) begin
                tx_sr   <= {2'b01, reg_wdata[5:0], arg_q, tx_crc, 1'b1};
                tx_left <= TX_LOAD;
            end
            unique case (state_q)
                S_SEND: if (tick_fall) begin
                    if (tx_left != '0) begin
                        cmd_out <= tx_sr[FRAME_BITS-1];
                        cmd_oe  <= 1'b1;
                        tx_sr   <= {tx_sr[FRAME_BITS-2:0], 1'b0};
                        tx_left <= tx_left - 1'b1;
                    end else begin
                        cmd_out  <= 1'b1;
                        cmd_oe   <= 1'b0;
                        tout_cnt <= tout_q;
                    end
                end
                S_WAIT: if (tick_rise) begin
                    if (!cmd_in) begin
                        rx_sr   <= {rx_sr[126:0], cmd_in};
                        rx_left <= cw_long ? RX_LONG_N : RX_SHORT_N;
                    end else if (tout_cnt == '0) begin
                        sts_ctout <= 1'b1;
                        cw_fail   <= 1'b1;
                    end else begin
                        tout_cnt <= tout_cnt - 1'b1;
                    end
                end
                S_RECV: if (tick_rise) begin
                    rx_sr   <= {rx_sr[126:0], cmd_in};
                    rx_left <= rx_left - 1'b1;
                end
                S_CHECK: begin
                    tout_cnt <= tout_q;
                    if (cw_long) begin
                        for (int k = 0; k < 4; k++) resp_q[k] <= rx_sr[32*k +: 32];
                    end else begin
                        resp_q[0] <= rx_sr[39:8];
                    end
                    if (crc_bad) begin
                        sts_crc <= 1'b1;
                        cw_fail <= 1'b1;
                    end
                end
                S_BUSY: if (tick_rise) begin
                    if (dat0_in) begin
                        sts_bdone <= 1'b1;
                    end else if (tout_cnt == '0) begin
                        sts_btout <= 1'b1;
                        cw_fail   <= 1'b1;
                    end else begin
                        tout_cnt <= tout_cnt - 1'b1;
                    end
                end
                S_DONE:  cw_start <= 1'b0;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (reg_addr)
            3'd0: reg_rdata = {16'h0, cw_start, cw_fail, 2'b00, cw_busy, cw_noresp,
                               cw_long, 1'b0, cw_wr, cw_rd, cw_idx};
            3'd1: reg_rdata = arg_q;
            3'd2: reg_rdata = tout_q;
            3'd3: reg_rdata = {21'h0, sts_bdone, 2'b00, sts_btout, sts_ctout,
                               1'b0, sts_crc, 4'h0};
            default: reg_rdata = resp_q[reg_addr[1:0]];
        endcase
    end

    AST_OE_IN_SEND: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_oe |-> state_q == S_SEND);  // R3
    AST_LINE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_fall |=> $stable(cmd_out));  // R3
    AST_START_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != S_IDLE |-> cw_start);  // R2
    AST_FAIL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cw_fail) |-> (sts_ctout || sts_crc || sts_btout));  // R6
    AST_TOUT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT && $past(state_q) == S_WAIT) |-> tout_cnt <= $past(tout_cnt));  // R8
    AST_ARG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_ARG && state_q != S_IDLE) |=> $stable(arg_q));  // R11
endmodule

// File: tb/sim_sd_cmd_engine.sv
`timescale 1ns/1ps
module sim_sd_cmd_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sd_clk, cmd_out, cmd_oe;
    logic        cmd_in = 1'b1;
    logic        dat0_in = 1'b1;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    sd_cmd_engine u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sd_clk(sd_clk),
        .cmd_out(cmd_out), .cmd_oe(cmd_oe), .cmd_in(cmd_in), .dat0_in(dat0_in)
    );

    function automatic logic [6:0] ref_crc(input logic [135:0] v, input int hi, input int lo);
        logic [6:0] c = '0;
        logic fb;
        for (int i = hi; i >= lo; i--) begin
            fb = v[i] ^ c[6];
            c = {c[5:0], 1'b0};
            if (fb) c = c ^ 7'h09;
        end
        return c;
    endfunction

    function automatic logic [47:0] exp_frame(input logic [5:0] idx, input logic [31:0] arg);
        logic [135:0] t = '0;
        t[39:0] = {2'b01, idx, arg};
        return {2'b01, idx, arg, ref_crc(t, 39, 0), 1'b1};
    endfunction

    task automatic check(input string req, input logic [135:0] act, input logic [135:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic capture(output logic [47:0] f, output logic oe_after);
        int guard = 0;
        do begin
            @(posedge sd_clk);
            guard++;
        end while (!cmd_oe && guard < 100);
        f[47] = cmd_out;
        for (int i = 46; i >= 0; i--) begin
            @(posedge sd_clk);
            f[i] = cmd_out;
        end
        @(posedge sd_clk);
        oe_after = cmd_oe;
    endtask

    task automatic send_resp(input logic [135:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge sd_clk);
            #1 cmd_in = v[i];
        end
        @(negedge sd_clk);
        #1 cmd_in = 1'b1;
    endtask

    task automatic wait_done(output logic [31:0] cw);
        for (int i = 0; i < 4000; i++) begin
            rd(3'd0, cw);
            if (!cw[15]) break;
        end
    endtask

    function automatic logic [135:0] short_resp(input logic [5:0] idx, input logic [31:0] st, input logic flip);
        logic [135:0] t = '0;
        t[39:0] = {2'b00, idx, st};
        return {88'h0, 2'b00, idx, st, ref_crc(t, 39, 0) ^ {6'h0, flip}, 1'b1};
    endfunction

    task automatic test_reset();
        logic [31:0] d;
        rd(3'd0, d); check("R1 cmd word", d, 0);
        rd(3'd2, d); check("R1 timeout", d, 32'h00F00000);
        rd(3'd3, d); check("R1 status", d, 0);
        check("R1 oe", cmd_oe, 0);
        check("R1 line", cmd_out, 1);
    endtask

    task automatic test_noresp();
        logic [47:0] f; logic oe; logic [31:0] d;
        wr(3'd1, 32'h0);
        wr(3'd0, 32'h8400);
        rd(3'd0, d); check("R2 start reads 1", d[15], 1);
        capture(f, oe);
        check("R3 frame idx0", f, exp_frame(6'd0, 32'h0));
        check("R3 crc byte", f[7:0], 8'h95);
        check("R3 oe released", oe, 0);
        wait_done(d);
        check("R4 done", d[15], 0);
        check("R4 no fail", d[14], 0);
    endtask

    task automatic test_short(input logic flip);
        logic [47:0] f; logic oe; logic [31:0] d;
        wr(3'd1, 32'h12345678);
        wr(3'd0, 32'h8000 | 17);
        capture(f, oe);
        check("R3 frame idx17", f, exp_frame(6'd17, 32'h12345678));
        send_resp(short_resp(6'd17, 32'hA5A50900, flip), 48);
        wait_done(d);
        check(flip ? "R6 fail flag" : "R5 fail clear", d[14], flip);
        rd(3'd4, d);
        check("R5 resp0", d, 32'hA5A50900);
        rd(3'd3, d);
        check(flip ? "R6 crc status" : "R5 status clean", d[4], flip);
        if (flip) begin
            wr(3'd3, 32'h0);
            rd(3'd3, d); check("R10 zero write keeps", d[4], 1);
            wr(3'd3, 32'h10);
            rd(3'd3, d); check("R10 w1c clears", d, 0);
        end
    endtask

    task automatic test_long();
        logic [47:0] f; logic oe; logic [31:0] d;
        logic [127:0] pl = {32'hDEAD0123, 32'h4567BEEF, 32'h0F1E2D3C, 32'h8091A2B3};
        wr(3'd0, 32'h8200 | 2);
        capture(f, oe);
        send_resp({8'h3F, pl}, 136);
        wait_done(d);
        check("R7 no fail", d[14], 0);
        for (int k = 0; k < 4; k++) begin
            rd(3'(4 + k), d);
            check("R7 resp word", d, pl[32*k +: 32]);
        end
    endtask

    task automatic test_timeout();
        logic [47:0] f; logic oe; logic [31:0] d;
        wr(3'd2, 32'd20);
        wr(3'd0, 32'h8000 | 8);
        capture(f, oe);
        repeat (15) @(posedge sd_clk);
        rd(3'd0, d); check("R8 still waiting", d[15], 1);
        wait_done(d);
        check("R8 finished", d[15], 0);
        check("R8 fail", d[14], 1);
        rd(3'd3, d); check("R8 ctout bit", d, 32'h40);
        wr(3'd3, 32'h40);
        rd(3'd3, d); check("R10 ctout cleared", d, 0);
        wr(3'd2, 32'h00F00000);
    endtask

    task automatic test_busy(input logic release_it);
        logic [47:0] f; logic oe; logic [31:0] d;
        wr(3'd2, 32'd10);
        dat0_in = 1'b0;
        wr(3'd0, 32'h8800 | 7);
        capture(f, oe);
        send_resp(short_resp(6'd7, 32'h00000900, 1'b0), 48);
        if (release_it) begin
            repeat (5) @(posedge sd_clk);
            rd(3'd0, d); check("R9 held by busy", d[15], 1);
            @(negedge sd_clk); #1 dat0_in = 1'b1;
            wait_done(d);
            check("R9 no fail", d[14], 0);
            rd(3'd3, d); check("R9 busy done bit", d, 32'h400);
            wr(3'd3, 32'h400);
        end else begin
            wait_done(d);
            check("R9 busy timeout fail", d[14], 1);
            rd(3'd3, d); check("R9 busy timeout bit", d, 32'h80);
            wr(3'd3, 32'h80);
            dat0_in = 1'b1;
        end
        rd(3'd3, d); check("R10 busy bits cleared", d, 0);
        wr(3'd2, 32'h00F00000);
    endtask

    task automatic test_ignore();
        logic [47:0] f; logic oe; logic [31:0] d;
        wr(3'd1, 32'hCAFEF00D);
        wr(3'd0, 32'h8400 | 5);
        fork
            capture(f, oe);
            begin
                repeat (30) @(posedge clk);
                wr(3'd1, 32'hDEADBEEF);
                wr(3'd0, 32'h8400 | 9);
                wr(3'd2, 32'd5);
            end
        join
        check("R11 frame unchanged", f, exp_frame(6'd5, 32'hCAFEF00D));
        wait_done(d);
        check("R11 index kept", d[5:0], 5);
        rd(3'd1, d); check("R11 arg kept", d, 32'hCAFEF00D);
        rd(3'd2, d); check("R11 timeout kept", d, 32'h00F00000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_noresp();
        test_short(1'b0);
        test_short(1'b1);
        test_long();
        test_timeout();
        test_busy(1'b1);
        test_busy(1'b0);
        test_ignore();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule